// File: doc/BRIEF.md
# Chained Vector Operation Issue Unit

This unit takes one parallel vector instruction and turns it into a stream of element operations. It runs that stream through a pipelined arithmetic datapath that is copied once per lane. For an add, subtract or multiply it reads element k at addresses A+k and B+k in every lane, one element per cycle. Each result is written back to address C+k once the pipeline latency has passed. The reads overlap the pipeline, so a whole instruction costs the fetch time plus one pipeline latency plus LANES write cycles. Issuing LANES separate single-element operations would instead cost the full per-operation time each.

A second mode clones across lanes. Every lane reads the word at address A once, and the unit captures all of those words. It then writes the word from lane j to address C+j in every lane. The lane memories are outside the unit: it drives their read and write ports and expects read data one cycle after a read enable. Integer add, subtract and multiply, truncated to the data width, stand in for the arithmetic.

Top module: `chain_vec_issue`

## Requirements
- R1: Opcode 0 adds, 1 subtracts (A minus B) and 2 multiplies. In every lane, the word written to address C+k equals the word at A+k combined with the word at B+k, for k = 0 to LANES-1, truncated to DW bits.
- R2: Cycle 1 is the cycle after the clock edge that accepts start. For add or subtract, element k is read in cycle 4+k and written in cycle 14+k, so the last write is in cycle LANES+13.
- R3: For multiply, element k is read in cycle 4+k and written in cycle 10+k, so the last write is in cycle LANES+9.
- R4: While the read enable stays high, the read addresses step up by one each cycle, starting at A on port A and at B on port B. Read data is taken one cycle after the enable.
- R5: The write address starts at C and steps up by one each cycle. The first write comes 10 cycles after the first read for add or subtract, and 6 cycles after it for multiply.
- R6: Opcode 3 (clone) reads address A on port A only, once, in cycle 3. Port B's enable stays low. In cycle 5+j it writes lane j's word to address C+j in every lane, so the last write is in cycle LANES+4.
- R7: The busy output is high from cycle 1 through the last write. The done output is high for exactly one cycle, the cycle after the last write.
- R8: A start request while busy is high is ignored. A start request in the done cycle is accepted.
- R9: During and after reset, busy, done and all read and write enables are low.
- R10: Read and write addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start request |
| opcode | input | 2 | 0 add, 1 subtract, 2 multiply, 3 clone |
| addr_a | input | AW | Base address of the first operand |
| addr_b | input | AW | Base address of the second operand |
| addr_c | input | AW | Base address of the destination |
| rd_en_a | output | 1 | Read enable, operand port A |
| rd_en_b | output | 1 | Read enable, operand port B |
| rd_addr_a | output | AW | Read address, port A (all lanes) |
| rd_addr_b | output | AW | Read address, port B (all lanes) |
| rd_data_a | input | LANES*DW | Port A read data, lane l in bits l*DW and up |
| rd_data_b | input | LANES*DW | Port B read data, lane l in bits l*DW and up |
| wr_en | output | 1 | Write enable (all lanes) |
| wr_addr | output | AW | Write address (all lanes) |
| wr_data | output | LANES*DW | Write data, lane l in bits l*DW and up |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with LANES=4, AW=8 and DW=16. An 8-bit address space lets a few vectors cross the top of memory, so wraparound is checked on both reads and writes. With four lanes the stream is shorter than either pipeline latency, so every cycle number in an instruction can be predicted and checked, including the done cycle and a back-to-back start. Sixteen-bit words keep the truncated products easy to compute in the bench, and they still show a multiply that has lost its upper bits.

// File: rtl/cvi_pkg.sv
package cvi_pkg;
   typedef enum logic [1:0] {
      OP_ADD   = 2'd0,
      OP_SUB   = 2'd1,
      OP_MUL   = 2'd2,
      OP_CLONE = 2'd3
   } vop_e;
endpackage

// File: rtl/cvi_seq.sv
module cvi_seq import cvi_pkg::*; #(
   parameter int LANES       = 8,
   parameter int AW          = 16,
   parameter int FETCH_ALU   = 3,
   parameter int FETCH_CLONE = 4,
   parameter int LAT_ADD     = 10,
   parameter int LAT_MUL     = 6,
   parameter int CW          = 6,
   parameter int LW          = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  vop_e          op_in,
   input  logic [AW-1:0] a_in,
   input  logic [AW-1:0] b_in,
   input  logic [AW-1:0] c_in,
   output logic          busy,
   output logic          done,
   output vop_e          op_q,
   output logic          rd_en_a,
   output logic          rd_en_b,
   output logic [AW-1:0] rd_addr_a,
   output logic [AW-1:0] rd_addr_b,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [LW-1:0] wr_idx,
   output logic          cap_en
);
   logic [CW-1:0] cnt, rd_first, wr_first, rd_len, last_cnt, rd_off, wr_off;
   logic [AW-1:0] a_q, b_q, c_q;
   logic          rd_act, wr_act;

   // Per-opcode schedule: first read slot, number of read slots, first write slot
   always_comb begin
      unique case (op_q)
         OP_CLONE: begin
            rd_first = CW'(FETCH_CLONE - 2);
            rd_len   = CW'(1);
            wr_first = CW'(FETCH_CLONE);
         end
         OP_MUL: begin
            rd_first = CW'(FETCH_ALU);
            rd_len   = CW'(LANES);
            wr_first = CW'(FETCH_ALU + LAT_MUL);
         end
         default: begin
            rd_first = CW'(FETCH_ALU);
            rd_len   = CW'(LANES);
            wr_first = CW'(FETCH_ALU + LAT_ADD);
         end
      endcase
      last_cnt = wr_first + CW'(LANES - 1);
      rd_off   = cnt - rd_first;
      wr_off   = cnt - wr_first;
      rd_act   = busy && (cnt >= rd_first) && (cnt < rd_first + rd_len);
      wr_act   = busy && (cnt >= wr_first) && (cnt <= last_cnt);
   end

   assign rd_en_a   = rd_act;
   assign rd_en_b   = rd_act && (op_q != OP_CLONE);
   assign rd_addr_a = a_q + AW'(rd_off);
   assign rd_addr_b = b_q + AW'(rd_off);
   assign wr_en     = wr_act;
   assign wr_addr   = c_q + AW'(wr_off);
   assign wr_idx    = LW'(wr_off);
   assign cap_en    = busy && (op_q == OP_CLONE) && (cnt == rd_first + CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
         op_q <= OP_ADD;
         a_q  <= '0;
         b_q  <= '0;
         c_q  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
               op_q <= op_in;
               a_q  <= a_in;
               b_q  <= b_in;
               c_q  <= c_in;
            end
         end else begin
            cnt <= cnt + CW'(1);
            if (cnt == last_cnt) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cvi_lane_alu.sv
module cvi_lane_alu import cvi_pkg::*; #(
   parameter int DW      = 32,
   parameter int LAT_ADD = 10,
   parameter int LAT_MUL = 6
) (
   input  logic          clk,
   input  vop_e          op,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   output logic [DW-1:0] res
);
   // One read-data cycle plus (LAT-1) register stages equals LAT cycles
   localparam int SADD = LAT_ADD - 1;
   localparam int SMUL = LAT_MUL - 1;

   logic [DW-1:0] sum_pipe  [SADD];
   logic [DW-1:0] prod_pipe [SMUL];

   always_ff @(posedge clk) begin
      sum_pipe[0]  <= (op == OP_SUB) ? (opa - opb) : (opa + opb);
      prod_pipe[0] <= opa * opb;
      for (int i = 1; i < SADD; i++) sum_pipe[i]  <= sum_pipe[i-1];
      for (int i = 1; i < SMUL; i++) prod_pipe[i] <= prod_pipe[i-1];
   end

   assign res = (op == OP_MUL) ? prod_pipe[SMUL-1] : sum_pipe[SADD-1];
endmodule

// File: rtl/cvi_clone_buf.sv
module cvi_clone_buf #(
   parameter int LANES = 8,
   parameter int DW    = 32,
   parameter int LW    = 3
) (
   input  logic                clk,
   input  logic                cap_en,
   input  logic [LANES*DW-1:0] lane_words,
   input  logic [LW-1:0]       idx,
   output logic [DW-1:0]       word
);
   logic [DW-1:0] held [LANES];

   always_ff @(posedge clk) begin
      if (cap_en) begin
         for (int l = 0; l < LANES; l++) held[l] <= lane_words[l*DW +: DW];
      end
   end

   assign word = held[idx];
endmodule

// File: rtl/chain_vec_issue.sv
module chain_vec_issue import cvi_pkg::*; #(
   parameter int LANES       = 8,
   parameter int AW          = 16,
   parameter int DW          = 32,
   parameter int FETCH_ALU   = 3,
   parameter int FETCH_CLONE = 4,
   parameter int LAT_ADD     = 10,
   parameter int LAT_MUL     = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          opcode,
   input  logic [AW-1:0]       addr_a,
   input  logic [AW-1:0]       addr_b,
   input  logic [AW-1:0]       addr_c,
   output logic                rd_en_a,
   output logic                rd_en_b,
   output logic [AW-1:0]       rd_addr_a,
   output logic [AW-1:0]       rd_addr_b,
   input  logic [LANES*DW-1:0] rd_data_a,
   input  logic [LANES*DW-1:0] rd_data_b,
   output logic                wr_en,
   output logic [AW-1:0]       wr_addr,
   output logic [LANES*DW-1:0] wr_data,
   output logic                busy,
   output logic                done
);
   localparam int MAXT = FETCH_ALU + FETCH_CLONE + LAT_ADD + LAT_MUL + LANES;
   localparam int CW   = $clog2(MAXT + 1);
   localparam int LW   = $clog2(LANES);

   if (LANES < 2 || LANES > 128 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two from 2 to 128");
   end
   if (LAT_ADD < 2 || LAT_MUL < 2) begin : g_bad_lat
      $error("pipeline latencies must be at least 2");
   end
   if (FETCH_ALU < 1 || FETCH_CLONE < 2) begin : g_bad_fetch
      $error("fetch lengths too short");
   end

   vop_e          op_q;
   logic          cap_en;
   logic [LW-1:0] wr_idx;
   logic [DW-1:0] clone_word;

   cvi_seq #(
      .LANES(LANES), .AW(AW), .FETCH_ALU(FETCH_ALU), .FETCH_CLONE(FETCH_CLONE),
      .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .CW(CW), .LW(LW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_in(vop_e'(opcode)),
      .a_in(addr_a), .b_in(addr_b), .c_in(addr_c),
      .busy(busy), .done(done), .op_q(op_q),
      .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_idx(wr_idx), .cap_en(cap_en)
   );

   cvi_clone_buf #(.LANES(LANES), .DW(DW), .LW(LW)) u_clone (
      .clk(clk), .cap_en(cap_en), .lane_words(rd_data_a),
      .idx(wr_idx), .word(clone_word)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DW-1:0] alu_res;
      cvi_lane_alu #(.DW(DW), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)) u_alu (
         .clk(clk), .op(op_q),
         .opa(rd_data_a[l*DW +: DW]), .opb(rd_data_b[l*DW +: DW]),
         .res(alu_res)
      );
      assign wr_data[l*DW +: DW] = (op_q == OP_CLONE) ? clone_word : alu_res;
   end
endmodule

// File: rtl/cvi_chk.sv
module cvi_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          rd_en_a,
   input logic [AW-1:0] rd_addr_a,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr
);
   // R4
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_a && $past(rd_en_a)) |-> (rd_addr_a == $past(rd_addr_a) + AW'(1)));

   // R5
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + AW'(1)));

   // R7
   done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_en) && !wr_en && !busy));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind chain_vec_issue cvi_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/chain_vec_issue_tb.sv
module chain_vec_issue_tb;
   localparam int LANES = 4;
   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int DEPTH = 256;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [1:0]          opcode = 2'd0;
   logic [AW-1:0]       addr_a = '0, addr_b = '0, addr_c = '0;
   logic                rd_en_a, rd_en_b, wr_en, busy, done;
   logic [AW-1:0]       rd_addr_a, rd_addr_b, wr_addr;
   logic [LANES*DW-1:0] rd_data_a = '0, rd_data_b = '0, wr_data;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   chain_vec_issue #(.LANES(LANES), .AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .addr_a(addr_a), .addr_b(addr_b), .addr_c(addr_c),
      .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done)
   );

   // Lane memories: synchronous read, one cycle after enable
   logic [DW-1:0] mem [LANES][DEPTH];
   always @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (rd_en_a) rd_data_a[l*DW +: DW] <= mem[l][rd_addr_a];
         if (rd_en_b) rd_data_b[l*DW +: DW] <= mem[l][rd_addr_b];
         if (wr_en)   mem[l][wr_addr]       <= wr_data[l*DW +: DW];
      end
   end

   function automatic logic [DW-1:0] fill(int l, int x);
      return DW'(l * 1237 + (x & 255) * 311 + 77);
   endfunction

   function automatic logic [DW-1:0] expv(logic [1:0] op, int l, int k,
                                          logic [AW-1:0] a, logic [AW-1:0] b);
      logic [DW-1:0] x, y;
      x = fill(l, a + k);
      y = fill(l, b + k);
      case (op)
         2'd0:    return x + y;
         2'd1:    return x - y;
         2'd2:    return x * y;
         default: return fill(k, a);
      endcase
   endfunction

   task automatic init_mem();
      for (int l = 0; l < LANES; l++)
         for (int x = 0; x < DEPTH; x++) mem[l][x] = fill(l, x);
   endtask

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_region(logic [1:0] op, logic [AW-1:0] a, logic [AW-1:0] b,
                             logic [AW-1:0] c, string req, string what);
      int bad = 0;
      int act = 0;
      int exp = 0;
      for (int l = 0; l < LANES; l++)
         for (int k = 0; k < LANES; k++)
            if (mem[l][AW'(c + k)] !== expv(op, l, k, a, b)) begin
               if (bad == 0) begin
                  act = mem[l][AW'(c + k)];
                  exp = expv(op, l, k, a, b);
               end
               bad++;
            end
      chk(bad == 0, req, what, act, exp);
   endtask

   // {opcode, A, B, C}
   localparam logic [25:0] VEC [6] = '{
      {2'd0, 8'h10, 8'h20, 8'h40},
      {2'd1, 8'h18, 8'h24, 8'h44},
      {2'd2, 8'h10, 8'h28, 8'h48},
      {2'd3, 8'h30, 8'h00, 8'h50},
      {2'd0, 8'hFE, 8'h30, 8'hFF},
      {2'd3, 8'h07, 8'h00, 8'hFE}
   };

   // Runs one instruction; optional injected busy start and done-cycle chaining
   task automatic run_op(logic [1:0] op, logic [AW-1:0] a, logic [AW-1:0] b,
                         logic [AW-1:0] c, int inj_rel, bit chain);
      int rel = 0, frd = -1, fwr = -1, nwr = 0, dcyc = -1;
      bit rd_ok = 1, wr_ok = 1;
      int lat, exp_rd, exp_wr;
      string treq, dreq;
      lat    = (op == 2'd2) ? 6 : 10;
      exp_rd = (op == 2'd3) ? 3 : 4;
      exp_wr = (op == 2'd3) ? 5 : 4 + lat;
      treq   = (op == 2'd3) ? "R6" : (op == 2'd2) ? "R3" : "R2";
      dreq   = (op == 2'd3) ? "R6" : "R1";
      @(negedge clk);
      start = 1'b1; opcode = op; addr_a = a; addr_b = b; addr_c = c;
      @(posedge clk);
      while (1) begin
         @(negedge clk);
         rel++;
         start = 1'b0;
         if (rel == inj_rel) begin
            start = 1'b1; opcode = 2'd2;
            addr_a = 8'h10; addr_b = 8'h20; addr_c = 8'hC0;
         end
         if (rd_en_a) begin
            if (frd < 0) frd = rel;
            if (rd_addr_a != AW'(a + (rel - frd))) rd_ok = 0;
         end
         if (rd_en_b) begin
            if (op == 2'd3) rd_ok = 0;
            if (rd_addr_b != AW'(b + (rel - frd))) rd_ok = 0;
         end
         if (wr_en) begin
            if (fwr < 0) fwr = rel;
            if (wr_addr != AW'(c + (rel - fwr))) wr_ok = 0;
            nwr++;
         end
         if (done) begin
            dcyc = rel;
            if (chain) begin
               start = 1'b1; opcode = op;
               addr_a = a; addr_b = b; addr_c = AW'(c + 8'h40);
            end
            break;
         end
         if (rel > 1000) break;
      end
      chk(frd == exp_rd, treq, "first read cycle", frd, exp_rd);
      chk(fwr == exp_wr, treq, "first write cycle", fwr, exp_wr);
      chk(dcyc == exp_wr + LANES, "R7", "done cycle", dcyc, exp_wr + LANES);
      chk(nwr == LANES, treq, "write count", nwr, LANES);
      chk(rd_ok, "R4/R10", "read address sequence", rd_ok, 1);
      chk(wr_ok, "R5/R10", "write address sequence", wr_ok, 1);
      if (op != 2'd3) chk(fwr - frd == lat, "R5", "write trails read", fwr - frd, lat);
      chk_region(op, a, b, c, dreq, "written results");
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
      if (chain) begin
         chk(busy == 1'b1, "R8", "start in done cycle accepted", busy, 1);
         rel = 0;
         while (!done && rel < 1000) begin
            @(negedge clk);
            rel++;
         end
         chk(rel == exp_wr + LANES - 1, "R8", "chained done cycle", rel, exp_wr + LANES - 1);
         chk_region(op, a, b, AW'(c + 8'h40), "R8", "chained results");
      end
   endtask

   initial begin
      #(200000 * 8);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      init_mem();
      repeat (3) @(negedge clk);
      chk({busy, done, rd_en_a, rd_en_b, wr_en} == 5'b0, "R9", "outputs in reset",
          {busy, done, rd_en_a, rd_en_b, wr_en}, 0);
      start = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R9", "start ignored in reset", busy, 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, rd_en_a, rd_en_b, wr_en} == 5'b0, "R9", "outputs after reset",
          {busy, done, rd_en_a, rd_en_b, wr_en}, 0);

      for (int v = 0; v < 6; v++) begin
         init_mem();
         run_op(VEC[v][25:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 0, 0);
      end

      // R8: start while busy must leave region C0 untouched
      init_mem();
      run_op(2'd0, 8'h10, 8'h20, 8'h44, 6, 0);
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R8", "no run from start while busy", busy, 0);
      begin
         int bad = 0;
         for (int l = 0; l < LANES; l++)
            for (int k = 0; k < LANES; k++)
               if (mem[l][8'hC0 + k] !== fill(l, 8'hC0 + k)) bad++;
         chk(bad == 0, "R8", "region of ignored start unchanged", bad, 0);
      end

      // R8: back-to-back start in the done cycle
      init_mem();
      run_op(2'd1, 8'h10, 8'h20, 8'h40, 0, 1);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule